// File: doc/BRIEF.md
# Double-to-Single Store Word Converter

This block sits beside a load/store unit and produces the 32-bit single-precision word that a single-precision floating-point store puts in memory. Its input is the 64-bit double-precision register value. Operands whose exponent already fits the single format, and operands that are zero, infinite or NaN, are converted by copying fixed bit slices. Operands whose value lands in the single-precision subnormal range are denormalized by a shifter that moves one bit per clock. Anything smaller than that range gives a word of all zeros. No rounding is done and no flags are raised.

Both sides use a valid/ready handshake. An operand is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high only while the block is idle. It drops from acceptance until the result has been taken, so one conversion is in flight at a time. The result is offered on `out_valid`/`out_data`. While `out_ready` is low, the consumer applies back-pressure: the result is held unchanged and no new operand is accepted. Bit positions below count from the LSB: `in_data[63]` is the sign, `in_data[62:52]` is the biased exponent E, and `in_data[51:0]` is the stored mantissa.

Top module: `dp_to_sp_store_cvt`

## Requirements
- R1: After a synchronous active-high reset, `in_ready` is 1 and `out_valid` is 0.
- R2: If E > 896, the result is `{in_data[63:62], in_data[58:29]}`.
- R3: If `in_data[62:0]` is all zero, the result is the same slice copy as R2. A positive zero gives 0x00000000 and a negative zero gives 0x80000000.
- R4: If 874 <= E <= 896, a 53-bit value F = {1, in_data[51:0]} is shifted right by 897-E places. The result is {sign, eight zero bits, F_shifted[51:29]}.
- R5: A slice-copy or zero-flush result is valid on the first edge after acceptance. A denormalized result is valid exactly 897-E edges after acceptance, so it takes between 1 and 23 steps.
- R6: If E < 874 and `in_data[62:0]` is non-zero, the result is 0x00000000, with the sign dropped.
- R7: From acceptance until the result is consumed, `in_ready` is 0. An operand presented during that time is not taken and does not change the result.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` does not change.
- R9: The operand 0x4040266660000000 converts to 0x42013333.
- R10: If E = 2047 (infinity or NaN), the result is the R2 slice copy. The single exponent field comes out all ones and the upper mantissa bits are kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Block idle, operand will be taken |
| in_data | input | 64 | Double-precision operand |
| out_valid | output | 1 | Result offered |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 32 | Single-precision store word |

## Verification
The assertions check the following on every cycle: `in_ready` and `out_valid` are never high together; a result under back-pressure stays stable; the step counter of the shifter falls by exactly one per clock and stays within 1 to 23; each step is a one-bit right shift; a denormalized result leaves the single exponent field at zero. The bit-exact values for each class can only be shown by the bench's scenarios. These cover the band edges 873, 874, 896 and 897, zeros of both signs, infinity, NaN, the reference operand and the measured latency. The bench scenarios also show that an operand offered while the block is busy is ignored.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  localparam int DP_W      = 64;
  localparam int SP_W      = 32;
  localparam int DP_EXP_W  = 11;
  localparam int SP_EXP_W  = 8;
  localparam int DP_MANT_W = DP_W - 1 - DP_EXP_W;
  localparam int SP_MANT_W = SP_W - 1 - SP_EXP_W;
  localparam int DP_BIAS   = 1023;
  localparam int SP_EMIN   = -126;
  localparam int WORK_W    = DP_MANT_W + 1;
  // first biased exponent that needs no shift step
  localparam int SUB_HI    = DP_BIAS + SP_EMIN;
  localparam int MAX_STEPS = SP_MANT_W;
  localparam int SUB_LO    = SUB_HI - MAX_STEPS;
  localparam int STEP_W    = $clog2(MAX_STEPS + 1);
  localparam int EXP_SKIP  = DP_EXP_W - SP_EXP_W;
  localparam int LOW_CPY_W = SP_W - 2;

  typedef enum logic [1:0] {CLS_COPY, CLS_DENORM, CLS_FLUSH} cls_e;
  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_HOLD} st_e;
endpackage

// File: rtl/dsc_classify.sv
module dsc_classify
  import dsc_pkg::*;
(
  input  logic [DP_W-1:0]   op_i,
  output cls_e              cls_o,
  output logic [STEP_W-1:0] steps_o,
  output logic [WORK_W-1:0] frac_o,
  output logic [SP_W-1:0]   copy_word_o
);
  logic [DP_EXP_W-1:0] exp_b;
  logic                mag_zero;

  assign exp_b    = op_i[DP_W-2 -: DP_EXP_W];
  assign mag_zero = ~|op_i[DP_W-2:0];

  always_comb begin
    if (mag_zero || (exp_b > DP_EXP_W'(SUB_HI - 1)))
      cls_o = CLS_COPY;
    else if (exp_b >= DP_EXP_W'(SUB_LO))
      cls_o = CLS_DENORM;
    else
      cls_o = CLS_FLUSH;
  end

  assign steps_o     = STEP_W'(SUB_HI - int'(exp_b));
  assign frac_o      = {1'b1, op_i[DP_MANT_W-1:0]};
  assign copy_word_o = {op_i[DP_W-1 -: 2], op_i[DP_W-3-EXP_SKIP -: LOW_CPY_W]};
endmodule

// File: rtl/dsc_denorm_shifter.sv
module dsc_denorm_shifter
  import dsc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load_i,
  input  logic [WORK_W-1:0]    frac_i,
  input  logic [STEP_W-1:0]    steps_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic [SP_MANT_W-1:0] mant_o
);
  logic [WORK_W-1:0] frac_q;
  logic [WORK_W-1:0] frac_nxt;
  logic [STEP_W-1:0] cnt_q;
  logic              busy_q;

  assign frac_nxt = frac_q >> 1;
  assign done_o   = busy_q && (cnt_q == STEP_W'(1));
  assign busy_o   = busy_q;
  assign mant_o   = frac_nxt[WORK_W-2 -: SP_MANT_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      frac_q <= '0;
    end else if (load_i && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= steps_i;
      frac_q <= frac_i;
    end else if (busy_q) begin
      frac_q <= frac_nxt;
      cnt_q  <= cnt_q - STEP_W'(1);
      if (cnt_q == STEP_W'(1)) busy_q <= 1'b0;
    end
  end

  p_count_down_r5: assert property (@(posedge clk) disable iff (rst)
    (busy_q && cnt_q > STEP_W'(1)) |=> (busy_q && cnt_q == $past(cnt_q) - STEP_W'(1)));
  p_count_range_r5: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (cnt_q != '0 && cnt_q <= STEP_W'(MAX_STEPS)));
  p_one_bit_step_r4: assert property (@(posedge clk) disable iff (rst)
    busy_q |=> (frac_q == ($past(frac_q) >> 1)));
endmodule

// File: rtl/dsc_out_stage.sv
module dsc_out_stage
  import dsc_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            load_i,
  input  logic [SP_W-1:0] word_i,
  input  logic            ready_i,
  output logic            valid_o,
  output logic [SP_W-1:0] data_o
);
  logic            valid_q;
  logic [SP_W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (load_i && !valid_q) begin
      valid_q <= 1'b1;
      data_q  <= word_i;
    end else if (valid_q && ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;

  p_hold_stable_r8: assert property (@(posedge clk) disable iff (rst)
    (valid_q && !ready_i) |=> (valid_q && $stable(data_q)));
endmodule

// File: rtl/dp_to_sp_store_cvt.sv
module dp_to_sp_store_cvt
  import dsc_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [DP_W-1:0] in_data,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [SP_W-1:0] out_data
);
  st_e                  st_q;
  logic                 sign_q;
  logic                 accept;
  cls_e                 cls;
  logic [STEP_W-1:0]    steps;
  logic [WORK_W-1:0]    frac;
  logic [SP_W-1:0]      copy_word;
  logic                 sh_busy;
  logic                 sh_done;
  logic [SP_MANT_W-1:0] sh_mant;
  logic                 ob_load;
  logic [SP_W-1:0]      ob_word;

  dsc_classify u_cls (
    .op_i       (in_data),
    .cls_o      (cls),
    .steps_o    (steps),
    .frac_o     (frac),
    .copy_word_o(copy_word)
  );

  dsc_denorm_shifter u_shift (
    .clk    (clk),
    .rst    (rst),
    .load_i (accept && cls == CLS_DENORM),
    .frac_i (frac),
    .steps_i(steps),
    .busy_o (sh_busy),
    .done_o (sh_done),
    .mant_o (sh_mant)
  );

  assign in_ready = (st_q == ST_IDLE);
  assign accept   = in_valid && in_ready;

  always_comb begin
    ob_load = 1'b0;
    ob_word = '0;
    if (accept && cls != CLS_DENORM) begin
      ob_load = 1'b1;
      ob_word = (cls == CLS_COPY) ? copy_word : '0;
    end else if (st_q == ST_SHIFT && sh_done) begin
      ob_load = 1'b1;
      ob_word = {sign_q, {SP_EXP_W{1'b0}}, sh_mant};
    end
  end

  dsc_out_stage u_out (
    .clk    (clk),
    .rst    (rst),
    .load_i (ob_load),
    .word_i (ob_word),
    .ready_i(out_ready),
    .valid_o(out_valid),
    .data_o (out_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      sign_q <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (accept) begin
          sign_q <= in_data[DP_W-1];
          st_q   <= (cls == CLS_DENORM) ? ST_SHIFT : ST_HOLD;
        end
        ST_SHIFT: if (sh_done) st_q <= ST_HOLD;
        ST_HOLD:  if (out_valid && out_ready) st_q <= ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  p_ready_excl_r7: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> !out_valid);
  p_busy_not_ready_r7: assert property (@(posedge clk) disable iff (rst)
    sh_busy |-> !in_ready);
  p_copy_one_cycle_r5: assert property (@(posedge clk) disable iff (rst)
    (accept && cls != CLS_DENORM) |=> out_valid);
  p_denorm_exp_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_SHIFT && sh_done) |=> (out_valid && out_data[SP_W-2 -: SP_EXP_W] == '0));
endmodule

// File: tb/dp_to_sp_store_cvt_bench.sv
module dp_to_sp_store_cvt_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit bp_mode = 1'b0;
  bit finished = 1'b0;

  typedef struct {
    logic [31:0] exp;
    int          acc;
    int          lat;
    string       tag;
  } item_t;
  item_t q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dp_to_sp_store_cvt u_dp_to_sp_store_cvt (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  function automatic logic [63:0] mk(input logic s, input int e, input logic [51:0] m);
    return {s, 11'(e), m};
  endfunction

  // reference from the requirements (LSB numbering)
  function automatic void model(input logic [63:0] x, output logic [31:0] w, output int lat);
    int e;
    logic [52:0] f;
    e = int'(x[62:52]);
    if (e > 896 || x[62:0] == '0) begin
      w = {x[63:62], x[58:29]}; lat = 0;
    end else if (e >= 874) begin
      f = {1'b1, x[51:0]};
      for (int i = 0; i < 897 - e; i++) f = f >> 1;
      w = {x[63], 8'h00, f[51:29]}; lat = 897 - e;
    end else begin
      w = '0; lat = 0;
    end
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  task automatic send(input logic [63:0] x, input string tag, input int junk);
    item_t t;
    model(x, t.exp, t.lat);
    t.tag = tag;
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = x;
    while (!in_ready) @(negedge clk);
    t.acc = cyc + 1;
    q.push_back(t);
    @(negedge clk);
    // R7: not ready after acceptance; junk offered while busy is ignored
    check(in_ready == 1'b0, "R7", "in_ready after accept", 32'(in_ready), 32'h0);
    for (int j = 0; j < junk; j++) begin
      in_data = ~x;
      @(negedge clk);
      check(in_ready == 1'b0, "R7", "in_ready while busy", 32'(in_ready), 32'h0);
    end
    in_valid = 1'b0;
  endtask

  // monitor / scoreboard
  initial begin
    bit prev_valid = 1'b0;
    bit prev_hold  = 1'b0;
    logic [31:0] held = '0;
    int bp = 0;
    forever begin
      @(negedge clk);
      if (bp_mode) begin bp++; out_ready = (bp % 3 == 0); end
      else out_ready = 1'b1;
      #1;
      if (!rst) begin
        if (prev_hold)
          check(out_valid && out_data == held, "R8", "held result", out_data, held);
        if (out_valid && !prev_valid && q.size() > 0)
          check(cyc - q[0].acc == q[0].lat, "R5", {"latency ", q[0].tag},
                32'(cyc - q[0].acc), 32'(q[0].lat));
        if (out_valid && out_ready) begin
          if (q.size() == 0) check(1'b0, "R7", "unexpected result", out_data, 32'h0);
          else begin
            item_t t;
            t = q.pop_front();
            check(out_data == t.exp, t.tag, "result", out_data, t.exp);
          end
        end
        prev_hold  = out_valid && !out_ready;
        held       = out_data;
        prev_valid = out_valid;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    #1;
    check(in_ready == 1'b1, "R1", "in_ready after reset", 32'(in_ready), 32'h1);
    check(out_valid == 1'b0, "R1", "out_valid after reset", 32'(out_valid), 32'h0);

    send(64'h4040266660000000, "R9", 0);
    send(64'h0000000000000000, "R3", 0);
    send(64'h8000000000000000, "R3", 0);
    send(mk(1'b0, 2047, 52'h0), "R10", 0);
    send(mk(1'b1, 2047, 52'hA5A5A5A5A5A5A), "R10", 0);
    send(mk(1'b0, 897, 52'h123456789ABCD), "R2", 0);
    send(mk(1'b1, 1100, 52'hFEDCBA9876543), "R2", 0);
    send(mk(1'b0, 896, 52'h8000000000000), "R4", 0);
    send(mk(1'b1, 885, 52'h3C3C3C3C3C3C3), "R4", 0);
    send(mk(1'b0, 874, 52'hFFFFFFFFFFFFF), "R4", 5);
    send(mk(1'b0, 873, 52'hFFFFFFFFFFFFF), "R6", 0);
    send(mk(1'b1, 0, 52'h0000000000001), "R6", 0);
    send(mk(1'b1, 500, 52'h5555555555555), "R6", 0);

    bp_mode = 1'b1;
    send(mk(1'b0, 890, 52'h0F0F0F0F0F0F0), "R8", 0);
    send(mk(1'b1, 1023, 52'h8000000000000), "R8", 0);
    send(mk(1'b0, 880, 52'hABCDEF0123456), "R8", 0);
    send(64'h4040266660000000, "R8", 0);

    while (q.size() > 0) @(negedge clk);
    repeat (4) @(negedge clk);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule